// File: doc/BRIEF.md
# File-Register Execute Unit

This block carries out the single-operand file-register operations of a small 8-bit core. It holds a 128 × 8 register file and an 8-bit working register. Each accepted operation reads the addressed file register, forms a result and writes it either to the working register or back into the same file register. The choice comes from a one-bit destination field. Only the zero flag is updated. The four operations are clear-file, clear-working, invert and decrement. Every one completes in a single clock.

Operations enter on a valid/ready pair. The unit never exerts back-pressure: `op_ready` is high whenever reset is released, so an operation is taken on every rising edge where `op_valid` is high. Holding `op_valid` high for consecutive cycles issues back-to-back operations. Each one sees the result of the one before it. A combinational debug port lets the surrounding logic look at any file register without disturbing execution.

Top module: `fileop_exec_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the working register, the zero flag and all 128 file registers read zero.
- R2: Opcode 3'b000 (clear-file) writes 00h to the addressed file register and sets the zero flag. The working register keeps its value whatever `op_dest` is.
- R3: Opcode 3'b001 (clear-working) writes 00h to the working register and sets the zero flag. No file register changes.
- R4: Opcode 3'b010 (invert) forms the bitwise inverse of the addressed register. With `op_dest`=0 the inverse goes to the working register. With `op_dest`=1 it goes back into the file register. The zero flag is set exactly when the result is 00h.
- R5: Opcode 3'b011 (decrement) forms the addressed register minus one. It uses the same destination rule and zero-flag rule as R4.
- R6: Decrementing a register that holds 00h yields FFh and clears the zero flag.
- R7: On a cycle where `op_valid` is low, the working register, the zero flag and every file register keep their values.
- R8: Opcodes with the top bit set (3'b1xx) are accepted but change neither the working register, the zero flag nor any file register.
- R9: `dbg_data` shows the file register at `dbg_addr` combinationally. In the cycle of a write to that address it still shows the old value. From the cycle after the write it shows the new value.
- R10: `op_ready` is high whenever `rst_n` is high. Operations on consecutive cycles to the same register chain, each using the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_ready | output | 1 | Unit accepts an operation this cycle |
| op_code | input | 3 | Operation selector (see R2–R5, R8) |
| op_addr | input | 7 | File register operand address |
| op_dest | input | 1 | 0: result to working register, 1: result to file |
| w_out | output | 8 | Working register |
| zero_flag | output | 1 | Zero flag |
| dbg_addr | input | 7 | Debug read address |
| dbg_data | output | 8 | File register contents at `dbg_addr` |

## Verification
Two functions can fall in the same cycle: a write-back into a file register and a debug read of that same register. Another case is a second operation that reads a register the first is still writing. The bench points `dbg_addr` at the target of an invert with `op_dest`=1. It samples `dbg_data` after the inputs settle but before the edge, and expects the old value. It samples again after the edge and expects the inverse. A pair of decrements issued on adjacent cycles to one register must leave the register two below its start. This shows that the second decrement read the first one's result.

// File: rtl/fxu_pkg.sv
package fxu_pkg;
  localparam int OP_W = 3;

  typedef logic [OP_W-1:0] op_t;

  localparam op_t OP_CLR_FILE = 3'b000;
  localparam op_t OP_CLR_W    = 3'b001;
  localparam op_t OP_INVERT   = 3'b010;
  localparam op_t OP_DECR     = 3'b011;
endpackage

// File: rtl/fxu_alu.sv
module fxu_alu #(
  parameter int DATA_W = 8
) (
  input  fxu_pkg::op_t      op_code,
  input  logic              op_dest,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] res_val,
  output logic              wr_w,
  output logic              wr_file,
  output logic              wr_z,
  output logic              z_val
);
  import fxu_pkg::*;

  always_comb begin
    res_val = '0;
    wr_w    = 1'b0;
    wr_file = 1'b0;
    wr_z    = 1'b0;
    unique case (op_code)
      OP_CLR_FILE: begin
        wr_file = 1'b1;
        wr_z    = 1'b1;
      end
      OP_CLR_W: begin
        wr_w = 1'b1;
        wr_z = 1'b1;
      end
      OP_INVERT: begin
        res_val = ~operand;
        wr_w    = ~op_dest;
        wr_file = op_dest;
        wr_z    = 1'b1;
      end
      OP_DECR: begin
        res_val = operand - 1'b1;
        wr_w    = ~op_dest;
        wr_file = op_dest;
        wr_z    = 1'b1;
      end
      default: ;
    endcase
  end

  assign z_val = (res_val == '0);

  // R6: a decrement of zero must wrap to all ones with zero flag cleared
  always_comb begin
    if (op_code == OP_DECR && operand == '0)
      a_r6_dec_wrap: assert (res_val == {DATA_W{1'b1}} && !z_val);
  end

  // R8: reserved opcodes request no write of any kind
  always_comb begin
    if (op_code[OP_W-1])
      a_r8_reserved_quiet: assert (!wr_w && !wr_file && !wr_z);
  end
endmodule

// File: rtl/fxu_regfile.sv
module fxu_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && wr_addr == ADDR_W'(i))
        mem[i] <= wr_data;
    end
  end

  assign rd_data  = mem[rd_addr];
  assign dbg_data = mem[dbg_addr];

  // R9: a written value is visible at the written address on the next cycle
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wr_addr)] == $past(wr_data));

  // R7: with no write the operand address keeps its contents
  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mem[$past(rd_addr)] == $past(rd_data));
endmodule

// File: rtl/fxu_wreg.sv
module fxu_wreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_w,
  input  logic [DATA_W-1:0] w_data,
  input  logic              we_z,
  input  logic              z_data,
  output logic [DATA_W-1:0] w_q,
  output logic              z_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      z_q <= 1'b0;
    end else begin
      if (we_w) w_q <= w_data;
      if (we_z) z_q <= z_data;
    end
  end

  // R7: without enables both registers hold
  a_r7_wreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_w && !we_z) |=> $stable(w_q) && $stable(z_q));
endmodule

// File: rtl/fileop_exec_unit.sv
module fileop_exec_unit #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dest,
  output logic [DATA_W-1:0] w_out,
  output logic              zero_flag,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  import fxu_pkg::*;

  logic              fire;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] res_val;
  logic              alu_wr_w, alu_wr_file, alu_wr_z, alu_z;

  assign op_ready = rst_n;
  assign fire     = op_valid && op_ready;

  fxu_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (fire && alu_wr_file),
    .wr_addr  (op_addr),
    .wr_data  (res_val),
    .rd_addr  (op_addr),
    .rd_data  (operand),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  fxu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_code (op_t'(op_code)),
    .op_dest (op_dest),
    .operand (operand),
    .res_val (res_val),
    .wr_w    (alu_wr_w),
    .wr_file (alu_wr_file),
    .wr_z    (alu_wr_z),
    .z_val   (alu_z)
  );

  fxu_wreg #(.DATA_W(DATA_W)) u_wreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_w   (fire && alu_wr_w),
    .w_data (res_val),
    .we_z   (fire && alu_wr_z),
    .z_data (alu_z),
    .w_q    (w_out),
    .z_q    (zero_flag)
  );

  // R2 / R3: both clear operations leave the zero flag set
  a_r2_r3_clear_sets_z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_CLR_FILE || op_code == OP_CLR_W)) |=> zero_flag);

  // R3: clear-working empties the working register
  a_r3_clrw_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CLR_W) |=> w_out == '0);

  // R4 / R5: with destination W, flag agrees with the new working value
  a_r4_r5_z_tracks_w: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_dest && (op_code == OP_INVERT || op_code == OP_DECR))
      |=> zero_flag == (w_out == '0));

  // R2 / R4 / R5: destination 1 never disturbs the working register
  a_r4_r5_dest_file_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_dest && op_code != OP_CLR_W) |=> $stable(w_out));

  // R7: an idle cycle changes neither W nor Z
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(w_out) && $stable(zero_flag));

  // R10: never stalls outside reset
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n) op_ready);
endmodule

// File: tb/test_fileop_exec_unit.sv
module test_fileop_exec_unit;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_ready;
  logic [2:0] op_code = 3'b000;
  logic [6:0] op_addr = '0;
  logic       op_dest = 1'b0;
  logic [7:0] w_out;
  logic       zero_flag;
  logic [6:0] dbg_addr = '0;
  logic [7:0] dbg_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fileop_exec_unit i_fileop_exec_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_addr(op_addr), .op_dest(op_dest),
    .w_out(w_out), .zero_flag(zero_flag), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  // vector: op(3) addr(7) dest(1) exp_w(8) exp_z(1) exp_file(8)
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {3'b011, 7'd5,   1'b1, 8'h00, 1'b0, 8'hFF},  // R5 R6 decrement 00 into file
    {3'b010, 7'd5,   1'b0, 8'h00, 1'b1, 8'hFF},  // R4 invert FF to W
    {3'b010, 7'd5,   1'b1, 8'h00, 1'b1, 8'h00},  // R4 invert FF back to file
    {3'b011, 7'd5,   1'b0, 8'hFF, 1'b0, 8'h00},  // R5 R6 decrement to W
    {3'b011, 7'd9,   1'b1, 8'hFF, 1'b0, 8'hFF},  // R5
    {3'b011, 7'd9,   1'b1, 8'hFF, 1'b0, 8'hFE},  // R5
    {3'b010, 7'd9,   1'b0, 8'h01, 1'b0, 8'hFE},  // R4
    {3'b001, 7'd9,   1'b1, 8'h00, 1'b1, 8'hFE},  // R3 file untouched
    {3'b010, 7'd9,   1'b1, 8'h00, 1'b0, 8'h01},  // R4
    {3'b011, 7'd9,   1'b1, 8'h00, 1'b1, 8'h00},  // R5 reaches zero
    {3'b011, 7'd127, 1'b0, 8'hFF, 1'b0, 8'h00},  // R5 R6 top address
    {3'b000, 7'd9,   1'b0, 8'hFF, 1'b1, 8'h00},  // R2 W kept
    {3'b110, 7'd127, 1'b1, 8'hFF, 1'b1, 8'h00}   // R8 reserved op
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [6:0] a, input logic d);
    @(negedge clk);
    op_code  = c;
    op_addr  = a;
    op_dest  = d;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 w", w_out, 8'h00);
    check("R1 z", {7'd0, zero_flag}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 128; a += 42) begin
      dbg_addr = 7'(a);
      #1 check("R1 file", dbg_data, 8'h00);
    end
    dbg_addr = 7'd127;
    #1 check("R1 file127", dbg_data, 8'h00);
    check("R10 ready", {7'd0, op_ready}, 8'h01);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      dbg_addr = v[24:18];
      issue(v[27:25], v[24:18], v[17]);
      #1;
      check("R2-5 vec w", w_out, v[16:9]);
      check("R2-5 vec z", {7'd0, zero_flag}, {7'd0, v[8]});
      check("R2-5 vec file", dbg_data, v[7:0]);
    end

    // R7: valid low, offered op ignored (W=FF Z=1, f5=00)
    dbg_addr = 7'd5;
    @(negedge clk);
    op_code = 3'b011; op_addr = 7'd5; op_dest = 1'b1; op_valid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check("R7 file", dbg_data, 8'h00);
    check("R7 w", w_out, 8'hFF);
    check("R7 z", {7'd0, zero_flag}, 8'h01);

    // R9: debug read of the register being written in the same cycle
    dbg_addr = 7'd20;
    @(negedge clk);
    op_code = 3'b010; op_addr = 7'd20; op_dest = 1'b1; op_valid = 1'b1;
    #1 check("R9 old during write", dbg_data, 8'h00);
    @(negedge clk);
    op_valid = 1'b0;
    #1 check("R9 new after write", dbg_data, 8'hFF);

    // R10: back-to-back decrements to one register chain
    dbg_addr = 7'd30;
    @(negedge clk);
    op_code = 3'b011; op_addr = 7'd30; op_dest = 1'b1; op_valid = 1'b1;
    repeat (2) @(negedge clk);
    op_valid = 1'b0;
    #1 check("R10 chained", dbg_data, 8'hFE);
    check("R10 z", {7'd0, zero_flag}, 8'h00);

    // R3: clear-working leaves file intact
    issue(3'b001, 7'd30, 1'b0);
    #1 check("R3 w", w_out, 8'h00);
    check("R3 file kept", dbg_data, 8'hFE);

    // R2: clear-file with dest 1, W untouched
    issue(3'b010, 7'd40, 1'b0); // W <= FF
    dbg_addr = 7'd30;
    issue(3'b000, 7'd30, 1'b1);
    #1 check("R2 file", dbg_data, 8'h00);
    check("R2 w", w_out, 8'hFF);
    check("R2 z", {7'd0, zero_flag}, 8'h01);

    // R1: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    dbg_addr = 7'd20;
    #1 check("R1 reset file", dbg_data, 8'h00);
    check("R1 reset w", w_out, 8'h00);
    check("R1 reset z", {7'd0, zero_flag}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule